// File: doc/BRIEF.md
# Latched Event Interrupt Register

This block gathers eight single-cycle hardware event strobes from a timing module into a sticky event register. A second register holds one enable bit per event. Any latched event whose enable bit is set drives an active-high interrupt line. Events are captured whether or not they are enabled. A single read of the event register returns its contents and clears every latched bit.

Software reaches the block through a simple parallel register port with address, write strobe, read strobe, write data and registered read data. The event register sits at address 0x12 and is read-only. The enable register sits at address 0x13 and can be read and written.

A strobe on either loss cause (loss of signal or loss of lock) also sets the mode-status-change bit. In manual mode the two loss bits stop showing their sticky copies and show the live status inputs instead. This applies both to read data and to the interrupt line.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset, the enable register, all latched events, `rd_data` and `irq` are all 0.
- R2: A 1 on `evt_strb[k]` at a clock edge sets bit k of the event register. The bit stays set until a clearing read. Reading address 0x12 presents the register on `rd_data` one cycle after the read strobe.
- R3: Events latch even when their enable bit is 0. A masked event does not raise `irq`.
- R4: A write to address 0x13 loads `wr_data` into the enable register. A read of 0x13 returns that value one cycle later.
- R5: `irq` is high exactly when some visible event bit and its enable bit are both 1. It rises in the cycle after the edge that latched the event.
- R6: A read of address 0x12 returns the value held before the read, then clears all latched bits.
- R7: An event strobe in the same cycle as a clearing read is kept set after the read.
- R8: Writes to address 0x12 leave the event register unchanged.
- R9: A strobe on bit 6 (loss of signal) or bit 7 (loss of lock) also sets bit 4 (mode status change). The bit assignments are:
  - bit 1: higher-priority reference available
  - bit 5: active reference change
  - bits 0, 2, 3: reference lost, reference regained, frame reference activity lost
  - the frame reference regaining activity maps to bit 0 when shared. This mapping sits with the event source, not this block.
- R10: While `manual` is 1, event bits 6 and 7 as read and as seen by `irq` equal `stat_los` and `stat_lol`. While `manual` is 0, they are the sticky bits.
- R11: Reads of any other address return 0 and clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strb | input | 8 | Event strobes, one per bit |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| manual | input | 1 | Manual reference-selection mode |
| stat_los | input | 1 | Live loss-of-signal status |
| stat_lol | input | 1 | Live loss-of-lock status |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
Three result timings apply, all measured from the clock edge that samples the stimulus:
- Read data appears one cycle after that edge.
- A latched event raises `irq` right after that edge.
- In manual mode, a change on the live status inputs reaches `irq` in the same cycle, with no edge needed.

The bench drives inputs just after a falling edge and lets the rising edge capture them. It compares the outputs on the next falling edge, where all three timings have settled. A behavioural model, advanced on each rising edge, supplies the expected outputs for every cycle. Directed checks with fixed values cover clearing, same-cycle capture, ignored writes and mirroring.

// File: rtl/evt_irq_reg.sv
module evt_irq_reg #(
  parameter int N        = 8,
  parameter int AW       = 8,
  parameter int EVT_ADDR = 'h12,
  parameter int EN_ADDR  = 'h13,
  parameter int LOS_BIT  = 6,
  parameter int LOL_BIT  = 7,
  parameter int MSC_BIT  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_strb,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [N-1:0]  wr_data,
  input  logic          manual,
  input  logic          stat_los,
  input  logic          stat_lol,
  output logic [N-1:0]  rd_data,
  output logic          irq
);

  localparam logic [N-1:0] MSC_MASK = N'(1) << MSC_BIT;

  logic [N-1:0] ev_q, en_q, vis, set_v;
  logic sel_evt, sel_en, clr;

  assign sel_evt = (addr == AW'(EVT_ADDR));
  assign sel_en  = (addr == AW'(EN_ADDR));
  assign clr     = rd_en & sel_evt;
  assign set_v   = evt_strb | ((evt_strb[LOS_BIT] | evt_strb[LOL_BIT]) ? MSC_MASK : '0);

  always_comb begin
    vis = ev_q;
    if (manual) begin
      vis[LOS_BIT] = stat_los;
      vis[LOL_BIT] = stat_lol;
    end
  end

  assign irq = |(vis & en_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= '0;
      en_q    <= '0;
      rd_data <= '0;
    end else begin
      ev_q <= (clr ? '0 : ev_q) | set_v;
      if (wr_en && sel_en) en_q <= wr_data;
      if (rd_en) rd_data <= sel_evt ? vis : (sel_en ? en_q : '0);
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) !rst_n |=> (ev_q == '0 && en_q == '0 && rd_data == '0)); // R1
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !clr |=> (($past(ev_q) & ~ev_q) == '0)); // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && sel_en) |=> en_q == $past(wr_data)); // R4
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (en_q == '0) |-> !irq); // R3
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr && evt_strb == '0) |=> ev_q == '0); // R6
  AST_KEEP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr && evt_strb != '0) |=> ((ev_q & $past(evt_strb)) == $past(evt_strb))); // R7
  AST_EVT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && sel_evt && !rd_en && evt_strb == '0) |=> $stable(ev_q)); // R8
  AST_LOSS_SETS_MSC: assert property (@(posedge clk) disable iff (!rst_n) (evt_strb[LOS_BIT] || evt_strb[LOL_BIT]) |=> ev_q[MSC_BIT]); // R9
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !sel_evt && !sel_en) |=> rd_data == '0); // R11

endmodule

// File: tb/tb_evt_irq_reg.sv
`timescale 1ns/1ps
module tb_evt_irq_reg;
  logic clk = 0, rst_n = 0;
  logic [7:0] evt_strb = 0, addr = 0, wr_data = 0;
  logic wr_en = 0, rd_en = 0, manual = 0, stat_los = 0, stat_lol = 0;
  logic [7:0] rd_data;
  logic irq;
  int errors = 0, checks = 0;
  string req = "R1";

  evt_irq_reg dut (.clk(clk), .rst_n(rst_n), .evt_strb(evt_strb), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .manual(manual),
    .stat_los(stat_los), .stat_lol(stat_lol), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  int m_ev = 0, m_en = 0, m_rd = 0;

  function automatic int seen();
    int v = m_ev;
    if (manual) begin
      v = stat_los ? (v | 64) : (v & ~64);
      v = stat_lol ? (v | 128) : (v & ~128);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ev = 0; m_en = 0; m_rd = 0;
    end else begin
      int nxt = m_ev;
      if (rd_en) m_rd = (addr == 8'h12) ? seen() : (addr == 8'h13) ? m_en : 0;
      if (rd_en && addr == 8'h12) nxt = 0;
      nxt = nxt | int'(evt_strb);
      if (evt_strb[6] || evt_strb[7]) nxt = nxt | 16;
      if (wr_en && addr == 8'h13) m_en = int'(wr_data);
      m_ev = nxt;
    end
  end

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk({req, " rd_data"}, int'(rd_data), m_rd);
    chk({req, " irq"}, int'(irq), ((seen() & m_en) != 0) ? 1 : 0);
  endtask

  task automatic idle();
    evt_strb = 0; wr_en = 0; rd_en = 0; addr = 8'h00;
  endtask

  task automatic pulse(logic [7:0] e);
    evt_strb = e; tick(); idle();
  endtask

  task automatic rd(logic [7:0] a);
    addr = a; rd_en = 1; tick(); idle();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1; tick(); idle();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    rst_n = 1; tick();
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 irq", int'(irq), 0);

    req = "R3";
    pulse(8'h01);
    chk("R3 masked irq", int'(irq), 0);
    req = "R2"; rd(8'h12);
    chk("R2 latched read", int'(rd_data), 8'h01);
    req = "R6"; rd(8'h12);
    chk("R6 cleared", int'(rd_data), 8'h00);

    req = "R4"; wr(8'h13, 8'h0F); rd(8'h13);
    chk("R4 enable readback", int'(rd_data), 8'h0F);

    req = "R5"; pulse(8'h20);
    chk("R5 masked bit5", int'(irq), 0);
    pulse(8'h02);
    chk("R5 enabled bit1", int'(irq), 1);
    rd(8'h12);
    chk("R6 pre-clear value", int'(rd_data), 8'h22);
    chk("R6 irq drops", int'(irq), 0);

    req = "R8"; wr(8'h12, 8'hFF); rd(8'h12);
    chk("R8 write ignored empty", int'(rd_data), 8'h00);
    pulse(8'h01); wr(8'h12, 8'h00); rd(8'h12);
    chk("R8 write ignored held", int'(rd_data), 8'h01);

    req = "R7"; pulse(8'h01);
    addr = 8'h12; rd_en = 1; evt_strb = 8'h08; tick(); idle();
    chk("R7 read returns old", int'(rd_data), 8'h01);
    rd(8'h12);
    chk("R7 same-cycle event kept", int'(rd_data), 8'h08);

    req = "R9"; pulse(8'h40); rd(8'h12);
    chk("R9 los sets msc", int'(rd_data), 8'h50);
    pulse(8'h80); rd(8'h12);
    chk("R9 lol sets msc", int'(rd_data), 8'h90);

    req = "R10"; manual = 1; stat_los = 1; tick();
    rd(8'h12);
    chk("R10 los mirrored", int'(rd_data), 8'h40);
    wr(8'h13, 8'h40);
    chk("R10 mirror drives irq", int'(irq), 1);
    stat_los = 0; tick();
    chk("R10 mirror follows low", int'(irq), 0);
    pulse(8'h80); rd(8'h12);
    chk("R10 sticky lol hidden", int'(rd_data), 8'h10);
    stat_lol = 1; rd(8'h12);
    chk("R10 lol mirrored", int'(rd_data), 8'h80);
    manual = 0; stat_lol = 0; tick();

    req = "R11"; pulse(8'h01); rd(8'h05);
    chk("R11 other addr zero", int'(rd_data), 8'h00);
    rd(8'h12);
    chk("R11 no clear", int'(rd_data), 8'h01);

    for (int i = 0; i < 8; i++) begin
      req = "R2"; pulse(8'(1 << i));
    end
    rd(8'h12);
    chk("R2 all bits", int'(rd_data), 8'hFF);
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule